// File: doc/BRIEF.md
# Region-Based Memory Protection Checker

This block decides, for every memory access, whether the access is allowed under a set of eight programmable protection regions. Each access presents a 32-bit address, an access kind (instruction fetch, data read or data write), a privilege flag and a global protection enable. The block looks for a matching region and picks the highest-numbered one when regions overlap. It then reads that region's 4-bit permission code from either the instruction or the data permission word. From that code it derives read, write and execute rights or a fault.

Software programs the region descriptors and the two permission words through a plain write port. No translation is done: the physical address returned is always the input address. One access can be checked every cycle, and each result appears one cycle later with a valid strobe.

Top module: `mem_region_guard`

## Requirements
- R1: While `prot_en` is low, the result grants read, write and execute, reports no fault, and sets `rsp_ftype` = 0 and `rsp_flevel` = 0.
- R2: A result appears on the clock edge after the access is sampled. `rsp_valid` is high exactly in the cycle after `req_valid`, and `rsp_paddr` equals the sampled `req_addr`.
- R3: Descriptor bit 0 enables its region. A region whose bit 0 is clear never matches, whatever its other bits hold.
- R4: Descriptor bits [5:1] hold a size exponent s. The address matches when it equals the descriptor in every bit above bit s, so the low s+1 bits are ignored.
- R5: When several enabled regions match, the region with the highest index supplies the permission.
- R6: When `prot_en` is high and no enabled region matches, a background fault is reported: `rsp_fault`=1, `rsp_ftype`=1, `rsp_flevel`=0, and all rights are 0.
- R7: A fetch (`req_kind`=0) takes its code from the instruction permission word. A read (1), a write (2) or the spare value 3, which is treated as a read, takes its code from the data permission word. Region n's code sits in bits [4n+3:4n] of the word.
- R8: The code sets the rights as follows. 1 gives privileged read/write, and a user access faults. 2 gives read for all and write only when privileged. 3 gives read/write for all. 5 gives privileged read only, and a user access faults. 6 gives read only for all. Every allowed access also has execute and read set.
- R9: Code 0 and the codes 4 and 7 to 15 always fault. Every permission failure reports `rsp_ftype`=2, `rsp_flevel`=1 and all rights 0.
- R10: A write to a region where the current privilege has no write right gives a permission fault. A fetch or read in a permitted region does not fault.
- R11: Reset clears every region enable and both permission words, so any checked access before programming gives a background fault.
- R12: The config port writes descriptor n when `cfg_sel`=n (0 to 7), the instruction word when `cfg_sel`=8 and the data word when `cfg_sel`=9. Writes with `cfg_sel` from 10 to 15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 4 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Access present |
| req_addr | input | 32 | Access address |
| req_kind | input | 2 | 0 fetch, 1 read, 2 write, 3 read |
| req_user | input | 1 | 1 = user, 0 = privileged |
| prot_en | input | 1 | Global protection enable |
| rsp_valid | output | 1 | Result valid |
| rsp_paddr | output | 32 | Physical address (equals access address) |
| rsp_rd | output | 1 | Read granted |
| rsp_wr | output | 1 | Write granted |
| rsp_ex | output | 1 | Execute granted |
| rsp_fault | output | 1 | Access faults |
| rsp_ftype | output | 2 | 0 none, 1 background, 2 permission |
| rsp_flevel | output | 2 | Fault level (1 for permission faults) |

## Verification
Each result is due one cycle after its access. The bench drives an access on a falling edge and samples every output on the next falling edge, after exactly one register stage. A configuration write reaches the check path on the edge that stores it, so an access issued in the cycle after a write already sees the new setting. The bench keeps to this by driving writes and accesses on falling edges only, and by reading results only at the falling edge one cycle after the access.

// File: rtl/prc_pkg.sv
package prc_pkg;

   localparam int unsigned PERM_NIB_W = 4;

   typedef enum logic [1:0] {
      KIND_FETCH = 2'd0,
      KIND_READ  = 2'd1,
      KIND_WRITE = 2'd2,
      KIND_SPARE = 2'd3
   } acc_kind_e;

   typedef enum logic [1:0] {
      FLT_NONE       = 2'd0,
      FLT_BACKGROUND = 2'd1,
      FLT_PERMISSION = 2'd2
   } fault_kind_e;

   typedef struct packed {
      logic rd;
      logic wr;
      logic ex;
   } rights_t;

endpackage

// File: rtl/prc_cfg_regs.sv
module prc_cfg_regs
   import prc_pkg::*;
#(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned NUM_REGIONS = 8,
   parameter int unsigned SEL_W       = 4
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  cfg_we,
   input  logic [SEL_W-1:0]                      cfg_sel,
   input  logic [ADDR_W-1:0]                     cfg_wdata,
   output logic [NUM_REGIONS-1:0][ADDR_W-1:0]    desc_o,
   output logic [NUM_REGIONS*PERM_NIB_W-1:0]     iperm_o,
   output logic [NUM_REGIONS*PERM_NIB_W-1:0]     dperm_o
);

   localparam int unsigned PERM_W    = NUM_REGIONS * PERM_NIB_W;
   localparam int unsigned SEL_IPERM = NUM_REGIONS;
   localparam int unsigned SEL_DPERM = NUM_REGIONS + 1;

   // R12: one storage slot per descriptor
   for (genvar n = 0; n < NUM_REGIONS; n++) begin : g_desc
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            desc_o[n] <= '0;
         end else if (cfg_we && (cfg_sel == SEL_W'(n))) begin
            desc_o[n] <= cfg_wdata;
         end
      end
   end

   // R11: both permission words cleared at reset
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         iperm_o <= '0;
         dperm_o <= '0;
      end else if (cfg_we) begin
         if (cfg_sel == SEL_W'(SEL_IPERM)) iperm_o <= cfg_wdata[PERM_W-1:0];
         if (cfg_sel == SEL_W'(SEL_DPERM)) dperm_o <= cfg_wdata[PERM_W-1:0];
      end
   end

endmodule

// File: rtl/prc_region_match.sv
module prc_region_match #(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned NUM_REGIONS = 8,
   parameter int unsigned SIZE_W      = 5,
   localparam int unsigned IDX_W      = $clog2(NUM_REGIONS)
) (
   input  logic [ADDR_W-1:0]                  addr_i,
   input  logic [NUM_REGIONS-1:0][ADDR_W-1:0] desc_i,
   output logic                               hit_o,
   output logic [IDX_W-1:0]                   idx_o
);

   logic [NUM_REGIONS-1:0] hit_vec;

   // R3 / R4: per-region enable and size-masked compare
   for (genvar n = 0; n < NUM_REGIONS; n++) begin : g_rgn
      logic [SIZE_W-1:0] exp_sz;
      logic [ADDR_W-1:0] low_mask;

      assign exp_sz = desc_i[n][SIZE_W:1];

      always_comb begin
         for (int b = 0; b < ADDR_W; b++) begin
            low_mask[b] = (b <= int'(exp_sz));
         end
      end

      assign hit_vec[n] = desc_i[n][0] &&
                          (((desc_i[n] ^ addr_i) & ~low_mask) == '0);
   end

   // R5: ascending scan, so the last (highest) hit wins
   always_comb begin
      hit_o = 1'b0;
      idx_o = '0;
      for (int n = 0; n < NUM_REGIONS; n++) begin
         if (hit_vec[n]) begin
            hit_o = 1'b1;
            idx_o = IDX_W'(n);
         end
      end
   end

endmodule

// File: rtl/prc_perm_decode.sv
module prc_perm_decode
   import prc_pkg::*;
(
   input  logic [PERM_NIB_W-1:0] code_i,
   input  logic                  user_i,
   input  logic                  write_i,
   output rights_t               rights_o,
   output logic                  fault_o
);

   logic    deny;
   rights_t grant;

   // R8 / R9: sparse permission code table
   always_comb begin
      deny     = 1'b0;
      grant.rd = 1'b1;
      grant.wr = 1'b0;
      grant.ex = 1'b1;
      unique case (code_i)
         4'd1: begin
            deny     = user_i;
            grant.wr = 1'b1;
         end
         4'd2: grant.wr = !user_i;
         4'd3: grant.wr = 1'b1;
         4'd5: deny     = user_i;
         4'd6: grant.wr = 1'b0;
         default: deny  = 1'b1;
      endcase
   end

   // R10: write without write right becomes a permission failure
   always_comb begin
      fault_o = deny || (write_i && !grant.wr);
      if (fault_o) begin
         rights_o = '0;
      end else begin
         rights_o = grant;
      end
   end

endmodule

// File: rtl/mem_region_guard_sva.sv
module mem_region_guard_sva #(
   parameter int unsigned ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [ADDR_W-1:0] req_addr,
   input logic [1:0]        req_kind,
   input logic              prot_en,
   input logic              rsp_valid,
   input logic [ADDR_W-1:0] rsp_paddr,
   input logic              rsp_rd,
   input logic              rsp_wr,
   input logic              rsp_ex,
   input logic              rsp_fault,
   input logic [1:0]        rsp_ftype,
   input logic [1:0]        rsp_flevel
);

   // R2
   valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   // R2
   paddr_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (rsp_paddr == $past(req_addr)));

   // R1
   bypass_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !prot_en) |=> (rsp_rd && rsp_wr && rsp_ex && !rsp_fault));

   // R9
   fault_no_rights_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault) |-> !(rsp_rd || rsp_wr || rsp_ex));

   // R9
   perm_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_ftype == 2'd2) |-> (rsp_fault && rsp_flevel == 2'd1));

   // R6
   bg_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_ftype == 2'd1) |-> (rsp_fault && rsp_flevel == 2'd0));

   // R8
   allowed_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_fault) |-> (rsp_ex && rsp_rd));

   // R10
   write_needs_w_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind == 2'd2) |=> (rsp_fault || rsp_wr));

endmodule

bind mem_region_guard mem_region_guard_sva #(.ADDR_W(ADDR_W)) u_sva (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_addr   (req_addr),
   .req_kind   (req_kind),
   .prot_en    (prot_en),
   .rsp_valid  (rsp_valid),
   .rsp_paddr  (rsp_paddr),
   .rsp_rd     (rsp_rd),
   .rsp_wr     (rsp_wr),
   .rsp_ex     (rsp_ex),
   .rsp_fault  (rsp_fault),
   .rsp_ftype  (rsp_ftype),
   .rsp_flevel (rsp_flevel)
);

// File: rtl/mem_region_guard.sv
module mem_region_guard
   import prc_pkg::*;
#(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned NUM_REGIONS = 8,
   parameter int unsigned SIZE_W      = 5,
   parameter int unsigned SEL_W       = $clog2(NUM_REGIONS + 2)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [SEL_W-1:0]  cfg_sel,
   input  logic [ADDR_W-1:0] cfg_wdata,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [1:0]        req_kind,
   input  logic              req_user,
   input  logic              prot_en,
   output logic              rsp_valid,
   output logic [ADDR_W-1:0] rsp_paddr,
   output logic              rsp_rd,
   output logic              rsp_wr,
   output logic              rsp_ex,
   output logic              rsp_fault,
   output logic [1:0]        rsp_ftype,
   output logic [1:0]        rsp_flevel
);

   localparam int unsigned IDX_W  = $clog2(NUM_REGIONS);
   localparam int unsigned PERM_W = NUM_REGIONS * PERM_NIB_W;

   // Elaboration-time parameter checks
   if (NUM_REGIONS < 2) begin : g_bad_regions
      $error("mem_region_guard: NUM_REGIONS must be at least 2");
   end
   if (PERM_W > ADDR_W) begin : g_bad_perm_w
      $error("mem_region_guard: permission word wider than write data");
   end
   if (SIZE_W + 1 > ADDR_W) begin : g_bad_size_w
      $error("mem_region_guard: size field does not fit in a descriptor");
   end
   if ((1 << SEL_W) < NUM_REGIONS + 2) begin : g_bad_sel_w
      $error("mem_region_guard: SEL_W too narrow for register select");
   end

   logic [NUM_REGIONS-1:0][ADDR_W-1:0] desc;
   logic [PERM_W-1:0]                  iperm;
   logic [PERM_W-1:0]                  dperm;
   logic                               hit;
   logic [IDX_W-1:0]                   hit_idx;
   logic [PERM_W-1:0]                  perm_word;
   logic [PERM_NIB_W-1:0]              perm_code;
   rights_t                            dec_rights;
   logic                               dec_fault;

   rights_t                            nxt_rights;
   logic                               nxt_fault;
   fault_kind_e                        nxt_ftype;
   logic [1:0]                         nxt_flevel;

   prc_cfg_regs #(
      .ADDR_W      (ADDR_W),
      .NUM_REGIONS (NUM_REGIONS),
      .SEL_W       (SEL_W)
   ) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_sel   (cfg_sel),
      .cfg_wdata (cfg_wdata),
      .desc_o    (desc),
      .iperm_o   (iperm),
      .dperm_o   (dperm)
   );

   prc_region_match #(
      .ADDR_W      (ADDR_W),
      .NUM_REGIONS (NUM_REGIONS),
      .SIZE_W      (SIZE_W)
   ) u_match (
      .addr_i (req_addr),
      .desc_i (desc),
      .hit_o  (hit),
      .idx_o  (hit_idx)
   );

   // R7: fetches use the instruction word, all else the data word
   assign perm_word = (req_kind == KIND_FETCH) ? iperm : dperm;

   always_comb begin
      perm_code = '0;
      for (int n = 0; n < NUM_REGIONS; n++) begin
         if (hit_idx == IDX_W'(n)) begin
            perm_code = perm_word[n*PERM_NIB_W +: PERM_NIB_W];
         end
      end
   end

   prc_perm_decode u_dec (
      .code_i   (perm_code),
      .user_i   (req_user),
      .write_i  (req_kind == KIND_WRITE),
      .rights_o (dec_rights),
      .fault_o  (dec_fault)
   );

   // R1 / R6 / R9: final result selection
   always_comb begin
      nxt_rights = '{rd: 1'b1, wr: 1'b1, ex: 1'b1};
      nxt_fault  = 1'b0;
      nxt_ftype  = FLT_NONE;
      nxt_flevel = 2'd0;
      if (prot_en) begin
         if (!hit) begin
            nxt_rights = '0;
            nxt_fault  = 1'b1;
            nxt_ftype  = FLT_BACKGROUND;
         end else if (dec_fault) begin
            nxt_rights = '0;
            nxt_fault  = 1'b1;
            nxt_ftype  = FLT_PERMISSION;
            nxt_flevel = 2'd1;
         end else begin
            nxt_rights = dec_rights;
         end
      end
   end

   // R2: single output register stage
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         rsp_paddr  <= '0;
         rsp_rd     <= 1'b0;
         rsp_wr     <= 1'b0;
         rsp_ex     <= 1'b0;
         rsp_fault  <= 1'b0;
         rsp_ftype  <= 2'd0;
         rsp_flevel <= 2'd0;
      end else begin
         rsp_valid  <= req_valid;
         rsp_paddr  <= req_addr;
         rsp_rd     <= nxt_rights.rd;
         rsp_wr     <= nxt_rights.wr;
         rsp_ex     <= nxt_rights.ex;
         rsp_fault  <= nxt_fault;
         rsp_ftype  <= nxt_ftype;
         rsp_flevel <= nxt_flevel;
      end
   end

endmodule

// File: tb/mem_region_guard_tb_top.sv
`timescale 1ns/1ps
module mem_region_guard_tb_top;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_we;
   logic [3:0]  cfg_sel;
   logic [31:0] cfg_wdata;
   logic        req_valid;
   logic [31:0] req_addr;
   logic [1:0]  req_kind;
   logic        req_user;
   logic        prot_en;
   logic        rsp_valid;
   logic [31:0] rsp_paddr;
   logic        rsp_rd, rsp_wr, rsp_ex, rsp_fault;
   logic [1:0]  rsp_ftype, rsp_flevel;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   mem_region_guard dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_addr(req_addr),
      .req_kind(req_kind), .req_user(req_user), .prot_en(prot_en),
      .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_rd(rsp_rd),
      .rsp_wr(rsp_wr), .rsp_ex(rsp_ex), .rsp_fault(rsp_fault),
      .rsp_ftype(rsp_ftype), .rsp_flevel(rsp_flevel)
   );

   function automatic logic [31:0] mkdesc(logic [31:0] base, int s, bit en);
      return (base & ~32'h3F) | (32'(s) << 1) | 32'(en);
   endfunction

   // Expected {fault, rd, wr, ex} from a permission code (R8, R9, R10)
   function automatic logic [3:0] exp_perm(logic [3:0] code, bit user, bit wr_acc);
      bit f = 1'b0;
      bit w = 1'b0;
      case (code)
         4'd1: begin f = user; w = 1'b1; end
         4'd2: w = !user;
         4'd3: w = 1'b1;
         4'd5: f = user;
         4'd6: w = 1'b0;
         default: f = 1'b1;
      endcase
      if (wr_acc && !w) f = 1'b1;
      return f ? 4'b1000 : {1'b0, 1'b1, w, 1'b1};
   endfunction

   task automatic cfg_write(logic [3:0] sel, logic [31:0] data);
      @(negedge clk);
      cfg_we    = 1'b1;
      cfg_sel   = sel;
      cfg_wdata = data;
      @(negedge clk);
      cfg_we    = 1'b0;
   endtask

   // Drive on a falling edge; the result is registered on the following
   // rising edge and sampled on the next falling edge.
   task automatic access_check(string req, logic [31:0] addr, logic [1:0] kind,
                               bit user, bit en, bit e_fault, bit e_rd,
                               bit e_wr, bit e_ex, logic [1:0] e_ftype,
                               logic [1:0] e_flevel);
      logic [39:0] act, exp;
      @(negedge clk);
      req_valid = 1'b1;
      req_addr  = addr;
      req_kind  = kind;
      req_user  = user;
      prot_en   = en;
      @(negedge clk);
      req_valid = 1'b0;
      act = {rsp_valid, rsp_paddr, rsp_fault, rsp_rd, rsp_wr, rsp_ex, rsp_ftype, rsp_flevel};
      exp = {1'b1, addr, e_fault, e_rd, e_wr, e_ex, e_ftype, e_flevel};
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s addr=%h kind=%0d user=%0d en=%0d actual=%h expected=%h",
                  req, addr, kind, user, en, act, exp);
      end
   endtask

   task automatic perm_check(string req, logic [31:0] addr, logic [1:0] kind,
                             bit user, logic [3:0] code);
      logic [3:0] e;
      e = exp_perm(code, user, kind == 2'd2);
      access_check(req, addr, kind, user, 1'b1, e[3], e[2], e[1], e[0],
                   e[3] ? 2'd2 : 2'd0, e[3] ? 2'd1 : 2'd0);
   endtask

   initial begin
      rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
      req_valid = 1'b0; req_addr = '0; req_kind = '0; req_user = 1'b0; prot_en = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R11: reset state
      checks++;
      if (rsp_valid !== 1'b0 || rsp_fault !== 1'b0) begin
         errors++;
         $display("FAIL R11 reset outputs actual=%b%b expected=00", rsp_valid, rsp_fault);
      end
      access_check("R11", 32'hCAFE_0000, 2'd1, 1'b0, 1'b1, 1, 0, 0, 0, 2'd1, 2'd0);
      access_check("R11", 32'h0000_0004, 2'd0, 1'b1, 1'b1, 1, 0, 0, 0, 2'd1, 2'd0);

      // R1: protection off passes everything through
      access_check("R1", 32'h8765_4321, 2'd2, 1'b1, 1'b0, 0, 1, 1, 1, 2'd0, 2'd0);
      access_check("R1", 32'hFFFF_FFFF, 2'd0, 1'b0, 1'b0, 0, 1, 1, 1, 2'd0, 2'd0);

      // R2: valid drops when no access is issued
      @(negedge clk);
      checks++;
      if (rsp_valid !== 1'b0) begin
         errors++;
         $display("FAIL R2 idle valid actual=%b expected=0", rsp_valid);
      end

      // R7 / R8 / R9 / R10: sweep region index, code, kind and privilege
      for (int n = 0; n < 8; n++) begin
         for (int r = 0; r < 8; r++) cfg_write(4'(r), mkdesc(32'h0, 31, r == n));
         for (int c = 0; c < 16; c++) begin
            logic [3:0]  icode, dcode;
            logic [31:0] iw, dw;
            icode = 4'(c);
            dcode = 4'(c + 5);
            iw = 32'hFFFF_FFFF;
            dw = 32'hFFFF_FFFF;
            iw[n*4 +: 4] = icode;
            dw[n*4 +: 4] = dcode;
            cfg_write(4'd8, iw);
            cfg_write(4'd9, dw);
            for (int u = 0; u < 2; u++) begin
               logic [31:0] a;
               a = 32'h1357_9BDF ^ (32'(c) << 20) ^ (32'(n) << 8);
               perm_check("R7", a, 2'd0, u[0], icode);
               perm_check("R8", a, 2'd1, u[0], dcode);
               perm_check("R10", a, 2'd2, u[0], dcode);
               perm_check("R7", a, 2'd3, u[0], dcode);
            end
         end
      end

      // R4: size exponent 11 gives a 4 KiB window at 0x0001_0000
      for (int r = 0; r < 8; r++) cfg_write(4'(r), 32'h0);
      cfg_write(4'd3, mkdesc(32'h0001_0000, 11, 1'b1));
      cfg_write(4'd9, 32'h0000_3000);
      access_check("R4", 32'h0001_0ABC, 2'd2, 1'b1, 1'b1, 0, 1, 1, 1, 2'd0, 2'd0);
      access_check("R4", 32'h0001_0FFF, 2'd1, 1'b1, 1'b1, 0, 1, 1, 1, 2'd0, 2'd0);
      access_check("R6", 32'h0001_1000, 2'd1, 1'b1, 1'b1, 1, 0, 0, 0, 2'd1, 2'd0);
      access_check("R6", 32'h0000_FFFC, 2'd1, 1'b0, 1'b1, 1, 0, 0, 0, 2'd1, 2'd0);

      // R3 / R5: overlapping regions, highest index wins, disabled ignored
      cfg_write(4'd3, 32'h0);
      cfg_write(4'd2, mkdesc(32'h0, 31, 1'b1));
      cfg_write(4'd5, mkdesc(32'h2000_0000, 15, 1'b1));
      cfg_write(4'd6, mkdesc(32'h0, 31, 1'b0));
      cfg_write(4'd9, 32'h0030_0600);
      access_check("R5", 32'h2000_1234, 2'd2, 1'b1, 1'b1, 0, 1, 1, 1, 2'd0, 2'd0);
      access_check("R5", 32'h3000_0000, 2'd2, 1'b1, 1'b1, 1, 0, 0, 0, 2'd2, 2'd1);
      access_check("R3", 32'h3000_0000, 2'd1, 1'b0, 1'b1, 0, 1, 0, 1, 2'd0, 2'd0);
      access_check("R5", 32'h2001_0000, 2'd1, 1'b1, 1'b1, 0, 1, 0, 1, 2'd0, 2'd0);

      // R12: selects 10..15 leave all state unchanged
      for (int s = 10; s < 16; s++) cfg_write(4'(s), 32'hFFFF_FFFF);
      access_check("R12", 32'h3000_0000, 2'd1, 1'b0, 1'b1, 0, 1, 0, 1, 2'd0, 2'd0);
      access_check("R12", 32'h2000_0010, 2'd2, 1'b0, 1'b1, 0, 1, 1, 1, 2'd0, 2'd0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule